// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Model

This block is a synthesizable behavioural model of a static memory with a dedicated read data port, a dedicated write data port and one shared address bus. Each access moves four words in an uninterruptible burst, so a port needs a new address only every second cycle of the main clock. Both halves of each memory clock period carry data, so the block runs on a double-rate clock `clk`. Each rising edge of `clk` is either a "K" edge, where the port selects are sampled, or a "K-bar" edge, where only data moves. `k_slot` reports which kind the next edge is.

Write words pass through a one-word write register before they reach the array. A read that overlaps a write to the same burst sees the newer bytes from that register, one byte at a time. The read port marks its words with `rd_valid` and holds `rd_data` at zero whenever it is idle. There is no back-pressure on either data stream. The write port takes a word on each of the four edges of an accepted burst. The read port presents one word per edge, and the consumer must take each word in the cycle where `rd_valid` is high. `rd_valid` has no ready counterpart.

Top module: `qdr_b4_sram`

## Requirements
- R1: After reset `k_slot` is 1, and it then inverts on every `clk` edge. A port select is honoured only on an edge where `k_slot` was 1 beforehand; a select held low only around a K-bar edge is ignored.
- R2: The two low bits of `addr` are ignored. A burst touches word addresses `{addr[AW-1:2], i}` for i = 0, 1, 2, 3 in ascending order.
- R3: On each port, a request that arrives within three edges after an accepted request on the same port is ignored. A new request is accepted at the earliest on the fourth edge after the previous one.
- R4: For a read accepted at edge E, `rd_valid` is 1 after edges E+1 to E+4 and 0 after edge E+5 unless a new burst follows. Word i is presented after edge E+1+i.
- R5: For a write accepted at edge E, word i is taken from `wr_data` on edge E+2+i.
- R6: `wr_be_n` is active low and applies to the word on the same edge. Bit b covers `wr_data[8b+7:8b]`. A byte whose bit is 1 keeps its old value in the array.
- R7: A read accepted on the K edge after a write to the same burst returns the new data for each enabled byte and the old data for each disabled byte. A read accepted on the same K edge as that write returns the previous contents.
- R8: While `rd_valid` is 0, `rd_data` is all zeros.
- R9: The read and write ports run independently. A read burst and a write burst to different addresses may overlap, and each completes unchanged.
- R10: Reset cancels any burst in progress. No `rd_valid` follows a read that was accepted before reset. The array contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; edges alternate between K and K-bar |
| rst_n | input | 1 | Synchronous active-low reset |
| k_slot | output | 1 | 1 when the next `clk` edge is a K edge |
| rd_sel_n | input | 1 | Active-low read request, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write request, sampled on K edges |
| addr | input | AW | Shared burst address; low two bits ignored |
| wr_data | input | DW | Write data word, one per edge during a write burst |
| wr_be_n | input | NB | Active-low byte enables for the current write word |
| rd_valid | output | 1 | High while a read word is on `rd_data` |
| rd_data | output | DW | Read data word, zero when idle |

## Verification
A table of write and read bursts covers full-word and partial-byte writes, reads with nonzero low address bits, and reads started on the same edge as a write, one edge pair after it, and well after it. This separates correct forwarding from reads that only see the array, and per-byte merging from whole-word replacement. Overlapping bursts to different addresses on the two ports show that the ports are independent. Directed tests then issue requests on K-bar edges, repeat requests in the middle of a burst and reset a read that is in flight. Each case must leave the memory or the read stream unchanged.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BURST_LEN = 4;
  localparam int IDX_W     = $clog2(BURST_LEN);
  localparam int RD_LEAD   = 1;
  localparam int WR_LEAD   = 2;

  typedef enum logic {
    PH_KBAR = 1'b0,
    PH_K    = 1'b1
  } qdr_phase_e;
endpackage

// File: rtl/qdr_burst_seq.sv
module qdr_burst_seq import qdr_pkg::*; #(
  parameter int AW   = 6,
  parameter int LEAD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          k_edge,
  input  logic          sel_n,
  input  logic [AW-1:0] addr,
  output logic          acc,
  output logic          word_due,
  output logic [AW-1:0] word_addr
);
  localparam int BW = AW - IDX_W;

  logic [IDX_W-1:0] cool_q;
  logic             start;
  logic [BW-1:0]    start_base;
  logic             dact_q;
  logic [IDX_W-1:0] didx_q;
  logic [BW-1:0]    dbase_q;
  logic             unused_lo;

  assign unused_lo = ^addr[IDX_W-1:0];
  assign acc = rst_n && k_edge && !sel_n && (cool_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)            cool_q <= '0;
    else if (acc)          cool_q <= IDX_W'(BURST_LEN - 1);
    else if (cool_q != '0) cool_q <= cool_q - 1'b1;
  end

  generate
    if (LEAD == 1) begin : g_direct
      assign start      = acc;
      assign start_base = addr[AW-1:IDX_W];
    end else begin : g_delay
      logic [LEAD-2:0] pend_q;
      logic [BW-1:0]   pbase_q [LEAD-1];
      always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else begin
          pend_q[0] <= acc;
          for (int k = 1; k < LEAD - 1; k++) pend_q[k] <= pend_q[k-1];
        end
      end
      always_ff @(posedge clk) begin
        pbase_q[0] <= addr[AW-1:IDX_W];
        for (int k = 1; k < LEAD - 1; k++) pbase_q[k] <= pbase_q[k-1];
      end
      assign start      = pend_q[LEAD-2];
      assign start_base = pbase_q[LEAD-2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dact_q <= 1'b0;
      didx_q <= '0;
    end else if (start) begin
      dact_q <= 1'b1;
      didx_q <= '0;
    end else if (dact_q) begin
      didx_q <= didx_q + 1'b1;
      if (didx_q == IDX_W'(BURST_LEN - 1)) dact_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start) dbase_q <= start_base;
  end

  assign word_due  = dact_q;
  assign word_addr = {dbase_q, didx_q};

  // R3
  burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (!$past(acc) && !$past(acc, 2) && !$past(acc, 3)));
endmodule

// File: rtl/qdr_wr_stage.sv
module qdr_wr_stage #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          due,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] wbe_n,
  output logic          stg_valid,
  output logic [AW-1:0] stg_addr,
  output logic [DW-1:0] stg_data,
  output logic [NB-1:0] stg_be
);
  always_ff @(posedge clk) begin
    if (!rst_n) stg_valid <= 1'b0;
    else        stg_valid <= due;
  end

  always_ff @(posedge clk) begin
    if (due) begin
      stg_addr <= waddr;
      stg_data <= wdata;
      stg_be   <= ~wbe_n;
    end
  end
endmodule

// File: rtl/qdr_array.sv
module qdr_array #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int BYTE_W = 8,
  parameter int NB     = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] wbe,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NB; b++) begin
        if (wbe[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path #(
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int BYTE_W = 8,
  parameter int NB     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          due,
  input  logic [AW-1:0] raddr,
  input  logic [DW-1:0] arr_rdata,
  input  logic          stg_valid,
  input  logic [AW-1:0] stg_addr,
  input  logic [DW-1:0] stg_data,
  input  logic [NB-1:0] stg_be,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic          hit;
  logic [DW-1:0] merged;

  assign hit = stg_valid && (stg_addr == raddr);

  always_comb begin
    merged = arr_rdata;
    for (int b = 0; b < NB; b++) begin
      if (hit && stg_be[b]) merged[b*BYTE_W +: BYTE_W] = stg_data[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !due) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b1;
      rd_data  <= merged;
    end
  end

  // R7
  fwd_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (due && hit && (&stg_be)) |=> (rd_data == $past(stg_data)));
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram import qdr_pkg::*; #(
  parameter  int DEPTH  = 64,
  parameter  int DW     = 16,
  parameter  int BYTE_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int NB     = DW / BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          k_slot,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic [NB-1:0] wr_be_n,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  qdr_phase_e    ph_q;
  logic          k_edge;
  logic          rd_acc, wr_acc;
  logic          rd_due, wr_due;
  logic [AW-1:0] rd_waddr, wr_waddr;
  logic          stg_valid;
  logic [AW-1:0] stg_addr;
  logic [DW-1:0] stg_data;
  logic [NB-1:0] stg_be;
  logic [DW-1:0] arr_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n)            ph_q <= PH_K;
    else if (ph_q == PH_K) ph_q <= PH_KBAR;
    else                   ph_q <= PH_K;
  end

  assign k_edge = (ph_q == PH_K);
  assign k_slot = k_edge;

  qdr_burst_seq #(.AW(AW), .LEAD(RD_LEAD)) i_rd_seq (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .sel_n(rd_sel_n), .addr(addr),
    .acc(rd_acc), .word_due(rd_due), .word_addr(rd_waddr)
  );

  qdr_burst_seq #(.AW(AW), .LEAD(WR_LEAD)) i_wr_seq (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .sel_n(wr_sel_n), .addr(addr),
    .acc(wr_acc), .word_due(wr_due), .word_addr(wr_waddr)
  );

  qdr_wr_stage #(.AW(AW), .DW(DW), .NB(NB)) i_wr_stage (
    .clk(clk), .rst_n(rst_n), .due(wr_due), .waddr(wr_waddr), .wdata(wr_data),
    .wbe_n(wr_be_n), .stg_valid(stg_valid), .stg_addr(stg_addr),
    .stg_data(stg_data), .stg_be(stg_be)
  );

  qdr_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BYTE_W(BYTE_W), .NB(NB)) i_array (
    .clk(clk), .we(stg_valid), .waddr(stg_addr), .wdata(stg_data), .wbe(stg_be),
    .raddr(rd_waddr), .rdata(arr_rdata)
  );

  qdr_rd_path #(.AW(AW), .DW(DW), .BYTE_W(BYTE_W), .NB(NB)) i_rd_path (
    .clk(clk), .rst_n(rst_n), .due(rd_due), .raddr(rd_waddr), .arr_rdata(arr_rdata),
    .stg_valid(stg_valid), .stg_addr(stg_addr), .stg_data(stg_data), .stg_be(stg_be),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R4
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> ##2 rd_valid ##1 rd_valid ##1 rd_valid ##1 rd_valid);

  // R5
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |-> ##3 stg_valid ##1 stg_valid ##1 stg_valid ##1 stg_valid);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  // R1
  k_only_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc || wr_acc) |=> !k_slot);
endmodule

// File: tb/test_qdr_b4_sram.sv
module test_qdr_b4_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        k_slot;
  logic        rd_sel_n = 1'b1;
  logic        wr_sel_n = 1'b1;
  logic [5:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_be_n = 2'b11;
  logic        rd_valid;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] mdl [64];

  always #4 clk = ~clk;

  qdr_b4_sram i_qdr_b4_sram (
    .clk(clk), .rst_n(rst_n), .k_slot(k_slot), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        dw;
    logic        dr;
    logic [3:0]  wat;
    logic [3:0]  rat;
    logic [5:0]  wa;
    logic [5:0]  ra;
    logic [15:0] base_d;
    logic [1:0]  be_n;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 4'd0, 4'd0, 6'h00, 6'h00, 16'h1000, 2'b00, 8'd5}, // R5 R6 fill
    '{1'b1, 1'b0, 4'd0, 4'd0, 6'h04, 6'h04, 16'h2000, 2'b00, 8'd5}, // R5 fill
    '{1'b1, 1'b0, 4'd0, 4'd0, 6'h08, 6'h08, 16'h3000, 2'b00, 8'd5}, // R5 fill
    '{1'b0, 1'b1, 4'd0, 4'd0, 6'h00, 6'h00, 16'h0000, 2'b11, 8'd4}, // R4 plain read
    '{1'b0, 1'b1, 4'd0, 4'd0, 6'h00, 6'h07, 16'h0000, 2'b11, 8'd2}, // R2 low bits ignored
    '{1'b1, 1'b1, 4'd0, 4'd2, 6'h00, 6'h00, 16'hA0B0, 2'b10, 8'd7}, // R7 forward low byte only
    '{1'b1, 1'b1, 4'd0, 4'd0, 6'h08, 6'h08, 16'h4000, 2'b00, 8'd7}, // R7 same edge reads old
    '{1'b1, 1'b1, 4'd2, 4'd0, 6'h0C, 6'h04, 16'h5000, 2'b00, 8'd9}, // R9 overlapping ports
    '{1'b1, 1'b1, 4'd0, 4'd4, 6'h04, 6'h04, 16'h6000, 2'b01, 8'd6}, // R6 high byte only
    '{0, 1'b1, 4'd0, 4'd0, 6'h00, 6'h0C, 16'h0000, 2'b11, 8'd9}     // R9 read back
  };

  task automatic chk(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic sync_k();
    @(negedge clk);
    while (k_slot !== 1'b1) @(negedge clk);
  endtask

  task automatic merge_word(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be_n);
    if (!be_n[0]) mdl[a][7:0]  = d[7:0];
    if (!be_n[1]) mdl[a][15:8] = d[15:8];
  endtask

  task automatic idle_inputs();
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; wr_be_n = 2'b11; wr_data = 16'hDEAD;
  endtask

  task automatic combo(input vec_t v);
    string rq;
    rq = $sformatf("R%0d", v.rq);
    sync_k();
    for (int t = 0; t < 14; t++) begin
      if (v.dw) begin
        for (int j = 0; j < 4; j++)
          if (int'(v.wat) + 2 + j == t - 2)
            merge_word({v.wa[5:2], 2'(j)}, v.base_d + 16'(j * 16'h1111), v.be_n);
      end
      if (v.dr) begin
        if (t >= int'(v.rat) + 2 && t <= int'(v.rat) + 5) begin
          logic [5:0] ea;
          ea = {v.ra[5:2], 2'(t - int'(v.rat) - 2)};
          chk(rd_valid === 1'b1 && rd_data === mdl[ea], rq, rd_data, mdl[ea]);
        end else if (t == int'(v.rat) + 6) begin
          chk(rd_valid === 1'b0 && rd_data === 16'h0, "R8", rd_data, 16'h0);
        end
      end
      idle_inputs();
      if (v.dr && t == int'(v.rat)) begin rd_sel_n = 1'b0; addr = v.ra; end
      if (v.dw && t == int'(v.wat)) begin wr_sel_n = 1'b0; addr = v.wa; end
      if (v.dw && t >= int'(v.wat) + 2 && t <= int'(v.wat) + 5) begin
        wr_data = v.base_d + 16'((t - int'(v.wat) - 2) * 16'h1111);
        wr_be_n = v.be_n;
      end
      @(negedge clk);
    end
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t rv;
    idle_inputs();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 R8 reset state
    chk(k_slot === 1'b1, "R1", {15'h0, k_slot}, 16'h1);
    chk(rd_valid === 1'b0 && rd_data === 16'h0, "R8", rd_data, 16'h0);
    @(negedge clk);
    chk(k_slot === 1'b0, "R1", {15'h0, k_slot}, 16'h0);

    for (int i = 0; i < NV; i++) combo(VT[i]);

    // R1: selects low only around K-bar edges are ignored
    sync_k();
    @(negedge clk);
    rd_sel_n = 1'b0; wr_sel_n = 1'b0; addr = 6'h00;
    @(negedge clk);
    idle_inputs();
    for (int t = 0; t < 7; t++) begin
      wr_data = 16'hBEEF; wr_be_n = 2'b00;
      chk(rd_valid === 1'b0, "R1", {15'h0, rd_valid}, 16'h0);
      @(negedge clk);
    end
    idle_inputs();
    rv = '{1'b0, 1'b1, 4'd0, 4'd0, 6'h00, 6'h00, 16'h0, 2'b11, 8'd1};
    combo(rv);

    // R3: second read mid-burst ignored
    sync_k();
    for (int t = 0; t < 9; t++) begin
      if (t >= 2 && t <= 5)
        chk(rd_valid === 1'b1 && rd_data === mdl[{4'h0, 2'(t - 2)}], "R3", rd_data, mdl[{4'h0, 2'(t - 2)}]);
      if (t == 6 || t == 7)
        chk(rd_valid === 1'b0, "R3", {15'h0, rd_valid}, 16'h0);
      idle_inputs();
      if (t == 0) begin rd_sel_n = 1'b0; addr = 6'h00; end
      if (t == 2) begin rd_sel_n = 1'b0; addr = 6'h04; end
      @(negedge clk);
    end

    // R3: second write mid-burst ignored
    sync_k();
    for (int t = 0; t < 10; t++) begin
      idle_inputs();
      if (t == 0) begin wr_sel_n = 1'b0; addr = 6'h10; end
      if (t == 2) begin wr_sel_n = 1'b0; addr = 6'h04; end
      if (t >= 2 && t <= 5) begin wr_data = 16'h0101 * 16'(t); wr_be_n = 2'b00; end
      if (t == 6 || t == 7) begin wr_data = 16'hFFFF; wr_be_n = 2'b00; end
      @(negedge clk);
    end
    idle_inputs();
    for (int j = 0; j < 4; j++) mdl[6'h10 + j] = 16'h0101 * 16'(j + 2);
    rv = '{1'b0, 1'b1, 4'd0, 4'd0, 6'h00, 6'h10, 16'h0, 2'b11, 8'd3};
    combo(rv);
    rv = '{1'b0, 1'b1, 4'd0, 4'd0, 6'h00, 6'h04, 16'h0, 2'b11, 8'd3};
    combo(rv);

    // R10: reset during a read burst
    sync_k();
    rd_sel_n = 1'b0; addr = 6'h00;
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(k_slot === 1'b1, "R10", {15'h0, k_slot}, 16'h1);
    for (int t = 0; t < 6; t++) begin
      chk(rd_valid === 1'b0 && rd_data === 16'h0, "R10", rd_data, 16'h0);
      @(negedge clk);
    end
    rv = '{1'b0, 1'b1, 4'd0, 4'd0, 6'h00, 6'h08, 16'h0, 2'b11, 8'd10};
    combo(rv);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule